// File: doc/BRIEF.md
# Whole-Page Hamming ECC Engine

This block sits beside the data bus of a NAND flash interface and watches every data transfer. It keeps one single-error-correcting, double-error-detecting Hamming code over the whole data area of a page. Software first issues a clear command. When a page is written, the block accumulates a 32-bit check code that software stores in the spare area. When a page is read, the block takes in the data and then the four stored check bytes, and it classifies the result.

The code has two 16-bit halves. The parity half is the XOR of the packed position `{word index, bit index}` of every 1 bit in the page. The complementary half is the XOR of the bitwise inverse of those same positions. After a read, the syndrome is the computed code XORed with the stored code, and it falls into one of four cases:

- zero: no error;
- a complementary pair: one flipped data bit, and the parity word gives its position directly;
- a single set bit: one flipped bit in the check code itself;
- anything else: a multiple error.

A freshly erased page reads back as all ones, including its check bytes. Such a page gives an all-ones multiple-error signature, so software can recognise it.

Top module: `page_ecc`

## Requirements
- R1: `page_sel` values 0, 1, 2 and 3 select 512, 1024, 2048 and 4096 data bytes. This is the data area of pages of 528, 1056, 2112 and 4224 bytes. The count of data strobes is the byte count, or half of it when `wide`=1. Only those strobes enter the code.
- R2: On a write (`rd_mode`=0), once all data strobes are taken, `par_word` equals the XOR over every 1 bit of `{word_index[11:0], bit_index[3:0]}`. `npar_word` equals the XOR of the 16-bit inverses of the same values.
- R3: A reset, or a cycle with `clr`=1, empties both accumulators, the stored code, the strobe count and all status. After it, `par_word`, `npar_word`, `done` and the three flags all read 0.
- R4: On a read, the check code follows directly after the last data strobe.
  - With `wide`=0 it arrives as 4 strobes on `din[7:0]`: parity low byte, parity high byte, complementary low byte, complementary high byte.
  - With `wide`=1 it arrives as 2 strobes: the parity halfword, then the complementary halfword.
- R5: A read with exactly one flipped data bit gives `err_hit`=1, `err_chk`=0 and `err_multi`=0. `par_word` then equals `{word_index[11:0], bit_index[3:0]}` of the flipped bit.
- R6: A read where exactly one bit of the stored check code differs gives `err_hit`=1, `err_chk`=1 and `err_multi`=0.
- R7: A read with two flipped data bits gives `err_hit`=1, `err_multi`=1 and `err_chk`=0. A page that is all ones, check bytes included, gives `err_multi`=1 with `par_word`=16'hFFFF.
- R8: Strobes after the data area on a write, or after the check code on a read, leave `par_word`, `npar_word` and the flags unchanged.
- R9: `done` and the flags are still 0 in the cycle right after the clock edge that takes the last check strobe. They are valid after the following edge and stay stable until the next clear.
- R10: A read whose check code matches the data gives `done`=1, all three flags 0, and `par_word`=`npar_word`=0.
- R11: With `wide`=0, only `din[7:0]` enters the code, and bit indices run 0 to 7. The upper byte of `din` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Clear command: empties code and status |
| page_sel | input | 2 | Page size select (512/1024/2048/4096 data bytes) |
| wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| rd_mode | input | 1 | 1 = page read with check, 0 = page write |
| stb | input | 1 | Data transfer strobe, one word per cycle |
| din | input | 16 | Bus data |
| par_word | output | 16 | Computed parity word, or the parity syndrome after a read check |
| npar_word | output | 16 | Computed complementary word, or its syndrome after a read check |
| done | output | 1 | Read check finished, flags valid |
| err_hit | output | 1 | Any error found |
| err_chk | output | 1 | Single-bit error inside the check code |
| err_multi | output | 1 | Uncorrectable multiple error |

## Verification
Write-mode pages carry several data patterns at both bus widths, with junk driven on the unused upper byte. This separates a correct position-XOR code from one that mixes up word and bit indices or lets the upper byte leak in. Single-bit flips are swept across many word and bit positions, including the last data word of several page sizes. That sweep exposes off-by-one page lengths and a wrong position report. Flips of single check-code bits, pairs of data flips, all-ones erased pages and clean reads separate the four syndrome classes from each other. Trailing strobes and mid-page clears show that nothing outside the defined window reaches the code.

// File: rtl/page_ecc.sv
module page_ecc #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int BW = 4,
  parameter int BASE_BYTES = 512,
  localparam int PW = AW + BW,
  localparam int CW = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    page_sel,
  input  logic          wide,
  input  logic          rd_mode,
  input  logic          stb,
  input  logic [DW-1:0] din,
  output logic [PW-1:0] par_word,
  output logic [PW-1:0] npar_word,
  output logic          done,
  output logic          err_hit,
  output logic          err_chk,
  output logic          err_multi
);

  logic [CW-1:0] cnt, nwords, nchk, slot;
  logic [PW-1:0] acc_p, acc_n, st_p, st_n, xp, sp, sn;
  logic          xo, pend, in_data, in_chk, last_chk;
  logic          syn_any, syn_one, syn_pair;

  assign nwords   = (CW'(BASE_BYTES) << page_sel) >> wide;
  assign nchk     = wide ? CW'(2) : CW'(4);
  assign in_data  = cnt < nwords;
  assign slot     = cnt - nwords;
  assign in_chk   = rd_mode && !in_data && (slot < nchk);
  assign last_chk = in_chk && (slot == nchk - CW'(1));

  always_comb begin
    xp = '0;
    xo = 1'b0;
    for (int b = 0; b < DW; b++) begin
      if (din[b] && (wide || b < 8)) begin
        xp = xp ^ {cnt[AW-1:0], BW'(b)};
        xo = ~xo;
      end
    end
  end

  assign sp       = acc_p ^ st_p;
  assign sn       = acc_n ^ st_n;
  assign syn_any  = |{sn, sp};
  assign syn_one  = $countones({sn, sp}) == 1;
  assign syn_pair = (sp ^ sn) == '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; acc_p <= '0; acc_n <= '0; st_p <= '0; st_n <= '0;
      pend <= 1'b0; done <= 1'b0;
      err_hit <= 1'b0; err_chk <= 1'b0; err_multi <= 1'b0;
    end else if (clr) begin
      cnt <= '0; acc_p <= '0; acc_n <= '0; st_p <= '0; st_n <= '0;
      pend <= 1'b0; done <= 1'b0;
      err_hit <= 1'b0; err_chk <= 1'b0; err_multi <= 1'b0;
    end else begin
      pend <= stb && last_chk;
      if (stb && in_data) begin
        acc_p <= acc_p ^ xp;
        acc_n <= acc_n ^ xp ^ {PW{xo}};
        cnt   <= cnt + CW'(1);
      end else if (stb && in_chk) begin
        cnt <= cnt + CW'(1);
        if (wide) begin
          if (slot[0]) st_n <= din[PW-1:0];
          else         st_p <= din[PW-1:0];
        end else begin
          case (slot[1:0])
            2'd0:    st_p[7:0]  <= din[7:0];
            2'd1:    st_p[15:8] <= din[7:0];
            2'd2:    st_n[7:0]  <= din[7:0];
            default: st_n[15:8] <= din[7:0];
          endcase
        end
      end
      if (pend) begin
        done      <= 1'b1;
        err_hit   <= syn_any;
        err_chk   <= syn_one;
        err_multi <= syn_any && !syn_one && !syn_pair;
      end
    end
  end

  assign par_word  = (done && rd_mode) ? sp : acc_p;
  assign npar_word = (done && rd_mode) ? sn : acc_n;

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!done && !err_hit && !err_chk && !err_multi && acc_p == '0 && acc_n == '0)); // R3
  AST_PEND_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && last_chk && !clr) |=> (pend && !done)); // R9
  AST_DONE_AFTER_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> done); // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (done && $stable({err_hit, err_chk, err_multi}))); // R9
  AST_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_chk && err_multi) && (err_hit || !(err_chk || err_multi))); // R6
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> ($stable(acc_p) && $stable(acc_n))); // R8

endmodule

// File: tb/sim_page_ecc.sv
module sim_page_ecc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [1:0]  page_sel = 2'd0;
  logic        wide = 1'b0;
  logic        rd_mode = 1'b0;
  logic        stb = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] par_word, npar_word;
  logic        done, err_hit, err_chk, err_multi;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  page_ecc u0 (.clk(clk), .rst_n(rst_n), .clr(clr), .page_sel(page_sel), .wide(wide),
    .rd_mode(rd_mode), .stb(stb), .din(din), .par_word(par_word), .npar_word(npar_word),
    .done(done), .err_hit(err_hit), .err_chk(err_chk), .err_multi(err_multi));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i, input int seed);
    return 16'(i * 40503 + seed * 9973) ^ 16'(i << 5) ^ 16'(seed << 11);
  endfunction

  task automatic start(input int sel, input bit wd, input bit rd);
    @(negedge clk);
    page_sel = 2'(sel); wide = wd; rd_mode = rd; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic put(input logic [15:0] d);
    stb = 1'b1; din = d;
    @(negedge clk);
    stb = 1'b0; din = 16'h0;
  endtask

  task automatic page(input int sel, input bit wd, input bit rd, input int seed, input bit erased,
                      input int fw1, input int fb1, input int fw2, input int fb2,
                      input logic [31:0] cflip, output logic [15:0] ep, output logic [15:0] en);
    int nw;
    logic [31:0] code;
    nw = (512 << sel) >> wd;
    ep = '0; en = '0;
    start(sel, wd, rd);
    for (int i = 0; i < nw; i++) begin
      logic [15:0] d, g;
      d = erased ? 16'hFFFF : pat(i, seed);
      g = wd ? d : (d & 16'h00FF);
      for (int b = 0; b < 16; b++)
        if (g[b]) begin
          ep = ep ^ {12'(i), 4'(b)};
          en = en ^ ~{12'(i), 4'(b)};
        end
      if (i == fw1) d[fb1] = ~d[fb1];
      if (i == fw2) d[fb2] = ~d[fb2];
      if (!wd) d[15:8] = 8'(i * 7 + 3);
      put(d);
    end
    code = erased ? 32'hFFFF_FFFF : ({en, ep} ^ cflip);
    if (rd) begin
      if (wd) begin
        put(code[15:0]); put(code[31:16]);
      end else begin
        put({8'hA5, code[7:0]});   put({8'h5A, code[15:8]});
        put({8'h3C, code[23:16]}); put({8'hC3, code[31:24]});
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ep, en;
    logic [15:0] hp, hn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk("R3 reset outputs", {par_word, npar_word}, 32'h0);
    chk("R3 reset status", {28'h0, done, err_hit, err_chk, err_multi}, 32'h0);

    // R2 R11: write-mode code at both widths, several patterns
    for (int wd = 0; wd < 2; wd++)
      for (int s = 1; s <= 3; s++) begin
        page(0, wd[0], 0, s, 0, -1, 0, -1, 0, 32'h0, ep, en);
        chk($sformatf("R2 R11 write code w%0d s%0d", wd, s), {npar_word, par_word}, {en, ep});
      end

    // R1: larger page lengths
    page(1, 0, 0, 7, 0, -1, 0, -1, 0, 32'h0, ep, en);
    chk("R1 write 1024B byte bus", {npar_word, par_word}, {en, ep});
    page(3, 1, 0, 8, 0, -1, 0, -1, 0, 32'h0, ep, en);
    chk("R1 write 4096B halfword bus", {npar_word, par_word}, {en, ep});

    // R8: trailing strobes after write data ignored
    put(16'h1234); put(16'hFFFF); put(16'h8001);
    @(negedge clk);
    chk("R8 write trailing strobes", {npar_word, par_word}, {en, ep});

    // R10 R4 R9: clean reads
    for (int wd = 0; wd < 2; wd++) begin
      page(0, wd[0], 1, 4 + wd, 0, -1, 0, -1, 0, 32'h0, ep, en);
      chk($sformatf("R9 not yet done w%0d", wd), {31'h0, done}, 32'h0);
      @(negedge clk);
      chk($sformatf("R10 R4 clean read status w%0d", wd), {28'h0, done, err_hit, err_chk, err_multi}, 32'h8);
      chk($sformatf("R10 clean syndrome w%0d", wd), {npar_word, par_word}, 32'h0);
    end

    // R5: single data flip sweep
    for (int wd = 0; wd < 2; wd++)
      for (int k = 0; k < 11; k++) begin
        int nw, w, b;
        nw = 512 >> wd;
        w = (k == 10) ? nw - 1 : (k * 53 + 1) % nw;
        b = (k * 3) % (wd ? 16 : 8);
        page(0, wd[0], 1, 20 + k, 0, w, b, -1, 0, 32'h0, ep, en);
        @(negedge clk);
        chk($sformatf("R5 single flip status w%0d k%0d", wd, k), {28'h0, done, err_hit, err_chk, err_multi}, 32'hC);
        chk($sformatf("R5 single flip position w%0d k%0d", wd, k), {16'h0, par_word}, {16'h0, 12'(w), 4'(b)});
      end
    // R1: single flip on the last word of a 2048-byte page
    page(2, 0, 1, 31, 0, 2047, 6, -1, 0, 32'h0, ep, en);
    @(negedge clk);
    chk("R1 last word 2048B status", {28'h0, done, err_hit, err_chk, err_multi}, 32'hC);
    chk("R1 last word 2048B position", {16'h0, par_word}, {16'h0, 12'd2047, 4'd6});

    // R6: single bit wrong in stored code
    for (int j = 0; j < 32; j += 5) begin
      page(0, j[0], 1, 40 + j, 0, -1, 0, -1, 0, 32'h1 << j, ep, en);
      @(negedge clk);
      chk($sformatf("R6 check-field flip bit%0d", j), {28'h0, done, err_hit, err_chk, err_multi}, 32'hE);
    end

    // R7: double data flip
    page(0, 0, 1, 50, 0, 10, 2, 300, 5, 32'h0, ep, en);
    @(negedge clk);
    chk("R7 double flip byte bus", {28'h0, done, err_hit, err_chk, err_multi}, 32'hD);
    page(0, 1, 1, 51, 0, 7, 7, 7, 9, 32'h0, ep, en);
    @(negedge clk);
    chk("R7 double flip same word", {28'h0, done, err_hit, err_chk, err_multi}, 32'hD);

    // R7: erased pages
    for (int wd = 0; wd < 2; wd++) begin
      page(0, wd[0], 1, 0, 1, -1, 0, -1, 0, 32'h0, ep, en);
      @(negedge clk);
      chk($sformatf("R7 erased status w%0d", wd), {28'h0, done, err_hit, err_chk, err_multi}, 32'hD);
      chk($sformatf("R7 erased signature w%0d", wd), {16'h0, par_word}, 32'h0000FFFF);
    end

    // R8 R9: strobes after the check code ignored; flags hold
    page(0, 1, 1, 60, 0, 33, 11, -1, 0, 32'h0, ep, en);
    @(negedge clk);
    hp = par_word; hn = npar_word;
    put(16'hFFFF); put(16'h0F0F); put(16'h0001);
    repeat (5) @(negedge clk);
    chk("R8 R9 read trailing strobes status", {28'h0, done, err_hit, err_chk, err_multi}, 32'hC);
    chk("R8 read trailing strobes syndrome", {npar_word, par_word}, {hn, hp});

    // R3: clear mid-page discards partial data
    start(0, 0, 1);
    for (int i = 0; i < 100; i++) put(16'(i * 91 + 5));
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R3 clear mid-page outputs", {npar_word, par_word}, 32'h0);
    page(0, 0, 1, 70, 0, 200, 3, -1, 0, 32'h0, ep, en);
    @(negedge clk);
    chk("R3 after clear single flip", {12'h0, done, err_hit, err_chk, err_multi, par_word}, {12'h0, 4'hC, 12'd200, 4'd3});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule